// File: doc/BRIEF.md
# I2C SCL Clock Period Generator

This block produces the serial clock of an I2C master. It drives SCL through an open-drain style output: `scl_low_o` high means the pad pulls the line low, and `scl_low_o` low means the line is released to its pull-up. The block reads the actual line level back on `scl_i`. Each low phase is timed from the cycle in which the block starts pulling. Each high phase is timed only from the cycle in which the line is first seen high. Rise time and any clock stretching by a target therefore never shorten the high time.

There are two pairs of period counts, one for standard speed and one for fast speed, and a speed field chooses the pair. The chosen counts are captured while the generator is idle, so the values in use cannot change while it is clocking. The `run_i` input starts the clock and stops it. A stop never cuts a low phase short. Sequencing of START and STOP conditions and data shifting belong to the surrounding controller.

Top module: `scl_gen`

## Requirements
- R1: After reset, and at any time while idle with `run_i` low, `scl_low_o` is 0 (line released).
- R2: Every low phase keeps `scl_low_o` at 1 for exactly L+1 consecutive clock cycles, where L is the effective low count.
- R3: Every high phase lasts exactly H+8 cycles, counted from the first released cycle in which `scl_i` is sampled 1 up to the cycle before `scl_low_o` returns to 1. H is the effective high count.
- R4: When `speed_i` is 2'b10 the fast pair (`fast_hcnt_i`, `fast_lcnt_i`) is used. For any other value (2'b01 is the normal standard code) the standard pair (`std_hcnt_i`, `std_lcnt_i`) is used.
- R5: While the line is released and `scl_i` is sampled 0, the block does not pull SCL low. Time spent waiting for the line to rise does not count toward the high phase, so a target may stretch the clock.
- R6: The effective high count is the selected high count, raised to 6 if it is below 6. The effective low count is the selected low count, raised to 8 if it is below 8.
- R7: The speed field and all four counts are taken while the block is idle. The values present at the clock edge that first samples `run_i` high are used for that whole run. Changes made while the block is running have no effect until it has stopped.
- R8: If `run_i` falls during a low phase, that low phase runs to its full length and the line is then left released. If `run_i` is low outside a low phase, no new low phase begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Clock enable: 1 runs SCL, 0 stops after any low phase in progress |
| speed_i | input | 2 | Speed field: 2'b10 selects fast, any other value selects standard |
| std_hcnt_i | input | CNT_W | Standard-speed high count |
| std_lcnt_i | input | CNT_W | Standard-speed low count |
| fast_hcnt_i | input | CNT_W | Fast-speed high count |
| fast_lcnt_i | input | CNT_W | Fast-speed low count |
| scl_i | input | 1 | Sampled SCL line level |
| scl_low_o | output | 1 | Pull SCL low when 1, release when 0 |

## Verification
Two cases put a control change and a phase event in the same cycle. In the first, the bench lowers `run_i` in the last cycle of a low phase, the cycle in which the phase counter reaches zero. It then expects a full low of L+1 cycles, followed by a released line with no further low phase. In the second, the bench raises `run_i` and writes a new low count in the same cycle, then writes a different value one cycle later. It expects the low phases to follow the first value, which was present at the capture edge. A bus model in the bench holds the line low for a programmable time after each release. This checks that high phases are counted from the sampled rise and not from the release.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HWAIT,
    ST_HIGH
  } scl_state_e;

  localparam int MIN_HI   = 6;
  localparam int MIN_LO   = 8;
  localparam int HI_OVH   = 8;
  localparam logic [1:0] SPD_FAST = 2'b10;

endpackage

// File: rtl/scl_cnt_sel.sv
module scl_cnt_sel
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [1:0]       speed_i,
  input  logic [CNT_W-1:0] std_hcnt_i,
  input  logic [CNT_W-1:0] std_lcnt_i,
  input  logic [CNT_W-1:0] fast_hcnt_i,
  input  logic [CNT_W-1:0] fast_lcnt_i,
  output logic [CNT_W-1:0] hi_eff_o,
  output logic [CNT_W-1:0] lo_eff_o
);

  localparam int NPH = 2;  // 0: high, 1: low

  logic               fast_sel;
  logic [CNT_W-1:0]   raw [NPH];
  logic [CNT_W-1:0]   eff [NPH];

  assign fast_sel = (speed_i == SPD_FAST);
  assign raw[0]   = fast_sel ? fast_hcnt_i : std_hcnt_i;
  assign raw[1]   = fast_sel ? fast_lcnt_i : std_lcnt_i;

  for (genvar g = 0; g < NPH; g++) begin : g_clamp
    localparam logic [CNT_W-1:0] FLOOR = (g == 0) ? CNT_W'(MIN_HI) : CNT_W'(MIN_LO);
    assign eff[g] = (raw[g] < FLOOR) ? FLOOR : raw[g];
  end

  assign hi_eff_o = eff[0];
  assign lo_eff_o = eff[1];

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             scl_i,
  input  logic [CNT_W-1:0] hi_eff_i,
  input  logic [CNT_W-1:0] lo_eff_i,
  output logic             scl_low_o
);

  localparam int CW1 = CNT_W + 1;
  // first sampled-high cycle is spent in ST_HWAIT, counter ends at zero
  localparam logic [CNT_W:0] HI_ADD = CW1'(HI_OVH - 2);

  scl_state_e       state_q, state_d;
  logic [CNT_W:0]   cnt_q, cnt_d;
  logic [CNT_W-1:0] hi_q, hi_d, lo_q, lo_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    hi_d    = hi_q;
    lo_d    = lo_q;
    unique case (state_q)
      ST_IDLE: begin
        hi_d = hi_eff_i;
        lo_d = lo_eff_i;
        if (run_i) begin
          state_d = ST_LOW;
          cnt_d   = {1'b0, lo_eff_i};
        end
      end
      ST_LOW: begin
        if (cnt_q == '0) state_d = run_i ? ST_HWAIT : ST_IDLE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_HWAIT: begin
        if (!run_i) begin
          state_d = ST_IDLE;
        end else if (scl_i) begin
          state_d = ST_HIGH;
          cnt_d   = {1'b0, hi_q} + HI_ADD;
        end
      end
      ST_HIGH: begin
        if (!run_i) begin
          state_d = ST_IDLE;
        end else if (cnt_q == '0) begin
          state_d = ST_LOW;
          cnt_d   = {1'b0, lo_q};
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      hi_q    <= CNT_W'(MIN_HI);
      lo_q    <= CNT_W'(MIN_LO);
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      hi_q    <= hi_d;
      lo_q    <= lo_d;
    end
  end

  assign scl_low_o = (state_q == ST_LOW);

  // R2
  lo_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOW && cnt_q != '0) |=> (state_q == ST_LOW));

  // R2
  lo_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOW && cnt_q == '0) |=> (state_q != ST_LOW));

  // R5
  stretch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HWAIT && !scl_i) |=> !scl_low_o);

  // R8
  no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && state_q != ST_LOW) |=> !scl_low_o);

  // R7
  lo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> ($stable(lo_q) && $stable(hi_q)));

endmodule

// File: rtl/scl_gen.sv
module scl_gen
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [1:0]       speed_i,
  input  logic [CNT_W-1:0] std_hcnt_i,
  input  logic [CNT_W-1:0] std_lcnt_i,
  input  logic [CNT_W-1:0] fast_hcnt_i,
  input  logic [CNT_W-1:0] fast_lcnt_i,
  input  logic             scl_i,
  output logic             scl_low_o
);

  logic [CNT_W-1:0] hi_eff, lo_eff;

  scl_cnt_sel #(.CNT_W(CNT_W)) u_sel (
    .speed_i     (speed_i),
    .std_hcnt_i  (std_hcnt_i),
    .std_lcnt_i  (std_lcnt_i),
    .fast_hcnt_i (fast_hcnt_i),
    .fast_lcnt_i (fast_lcnt_i),
    .hi_eff_o    (hi_eff),
    .lo_eff_o    (lo_eff)
  );

  scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .scl_i     (scl_i),
    .hi_eff_i  (hi_eff),
    .lo_eff_i  (lo_eff),
    .scl_low_o (scl_low_o)
  );

endmodule

// File: tb/scl_gen_bench.sv
module scl_gen_bench;

  localparam int CLK_P = 10;
  localparam int CW    = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          run_i = 1'b0;
  logic [1:0]    speed_i = 2'b01;
  logic [CW-1:0] std_hcnt_i = 16'd10, std_lcnt_i = 16'd12;
  logic [CW-1:0] fast_hcnt_i = 16'd7, fast_lcnt_i = 16'd9;
  logic          scl_i;
  logic          scl_low_o;

  int n_vec = 0, n_bad = 0;
  int hold_dly = 0;
  int rcnt = 0;
  int lrun = 0, hrun = 0, last_low = 0, last_high = 0, nlow = 0, nhigh = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  scl_gen #(.CNT_W(CW)) u_scl_gen (
    .clk_i, .rst_ni, .run_i, .speed_i,
    .std_hcnt_i, .std_lcnt_i, .fast_hcnt_i, .fast_lcnt_i,
    .scl_i, .scl_low_o
  );

  // bus model: pull-up takes hold_dly cycles to raise the line
  always @(posedge clk_i) begin
    if (scl_low_o) rcnt <= 0;
    else if (rcnt < 1000) rcnt <= rcnt + 1;
  end
  assign scl_i = !scl_low_o && (rcnt >= hold_dly);

  // phase length monitor
  always @(posedge clk_i) begin
    #1;
    if (!rst_ni) begin
      lrun = 0; hrun = 0;
    end else if (scl_low_o) begin
      lrun++;
      if (hrun > 0) begin last_high = hrun; hrun = 0; nhigh++; end
    end else begin
      if (lrun > 0) begin last_low = lrun; lrun = 0; nlow++; end
      if (scl_i) hrun++;
    end
  end

  task automatic check(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start_run();
    @(negedge clk_i);
    hrun = 0;
    run_i = 1'b1;
  endtask

  task automatic stop_run();
    @(negedge clk_i);
    run_i = 1'b0;
    for (int i = 0; i < 4000 && scl_low_o; i++) @(negedge clk_i);
    repeat (5) @(negedge clk_i);
  endtask

  task automatic wait_lows(int n);
    int tgt = nlow + n;
    for (int i = 0; i < 20000 && nlow < tgt; i++) @(negedge clk_i);
  endtask

  task automatic measure(string req, int exp_lo, int exp_hi);
    start_run();
    wait_lows(3);
    check({req, " low"}, last_low, exp_lo);
    check({req, " high"}, last_high, exp_hi);
    stop_run();
  endtask

  task automatic t_reset();
    check("R1 reset", int'(scl_low_o), 0);
    repeat (20) @(negedge clk_i);
    check("R1 idle", int'(scl_low_o), 0);
    check("R1 no lows", nlow, 0);
  endtask

  task automatic t_modes();
    speed_i = 2'b01; measure("R2 R3 std", 13, 18);
    speed_i = 2'b10; measure("R4 fast", 10, 15);
    speed_i = 2'b00; measure("R4 code0 std", 13, 18);
    speed_i = 2'b11; measure("R4 code3 std", 13, 18);
    speed_i = 2'b01;
  endtask

  task automatic t_stretch();
    hold_dly = 5;  measure("R5 stretch5", 13, 18);
    hold_dly = 17; measure("R5 stretch17", 13, 18);
    hold_dly = 0;
  endtask

  task automatic t_clamp();
    std_hcnt_i = 2; std_lcnt_i = 3; measure("R6 below", 9, 14);
    std_hcnt_i = 6; std_lcnt_i = 8; measure("R6 at floor", 9, 14);
    std_hcnt_i = 7; std_lcnt_i = 9; measure("R6 above", 10, 15);
    std_hcnt_i = 10; std_lcnt_i = 12;
  endtask

  task automatic t_live_change();
    start_run();
    wait_lows(1);
    @(negedge clk_i);
    std_hcnt_i = 30; std_lcnt_i = 25; speed_i = 2'b10;
    wait_lows(3);
    check("R7 run high kept", last_high, 18);
    check("R7 run low kept", last_low, 13);
    stop_run();
    speed_i = 2'b01;
    measure("R7 after restart", 26, 38);
    std_hcnt_i = 10; std_lcnt_i = 12;
  endtask

  task automatic t_stop_mid_low();
    int n0;
    start_run();
    wait_lows(2);
    for (int i = 0; i < 4000 && !(scl_low_o && lrun == 3); i++) @(negedge clk_i);
    run_i = 1'b0;
    n0 = nlow;
    repeat (60) @(negedge clk_i);
    check("R8 low completed", last_low, 13);
    check("R8 one low ended", nlow, n0 + 1);
    check("R8 released", int'(scl_low_o), 0);
  endtask

  task automatic t_stop_high();
    int n0;
    start_run();
    wait_lows(2);
    for (int i = 0; i < 4000 && !(!scl_low_o && scl_i && hrun == 2); i++) @(negedge clk_i);
    run_i = 1'b0;
    n0 = nlow;
    repeat (60) @(negedge clk_i);
    check("R8 no low after high stop", nlow, n0);
    check("R8 line released", int'(scl_low_o), 0);
  endtask

  // run falls in the cycle the low counter expires
  task automatic t_stop_last_low_cycle();
    int n0;
    start_run();
    wait_lows(2);
    for (int i = 0; i < 4000 && !(scl_low_o && lrun == 13); i++) @(negedge clk_i);
    run_i = 1'b0;
    n0 = nlow;
    repeat (60) @(negedge clk_i);
    check("R8 last-cycle stop low", last_low, 13);
    check("R8 last-cycle stop count", nlow, n0 + 1);
    check("R2 last-cycle stop no new low", int'(scl_low_o), 0);
  endtask

  // count change on the same edge as run rise is captured
  task automatic t_capture_edge();
    @(negedge clk_i);
    hrun = 0;
    run_i = 1'b1;
    std_lcnt_i = 20;
    @(negedge clk_i);
    std_lcnt_i = 40;
    wait_lows(3);
    check("R7 capture-edge low", last_low, 21);
    check("R3 capture-edge high", last_high, 18);
    stop_run();
    std_lcnt_i = 12;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_modes();
    t_stretch();
    t_clamp();
    t_live_change();
    t_stop_mid_low();
    t_stop_high();
    t_stop_last_low_cycle();
    t_capture_edge();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule